// File: doc/BRIEF.md
# ADC Register Bridge with Command and Result Queues

This block connects a processor-side register port to the 16-bit register space of a monitoring converter. Software does not touch the converter registers directly. It pushes 32-bit command words into a 16-entry command queue. A small engine takes the commands one at a time and runs each one as a register read, a register write or a no-op against a backend register array. The rate is set by a programmable clock divider. A command occupies the engine for 32 divided ticks, which models the time of a serial transfer.

Each command the engine completes pushes exactly one word into a 16-entry result queue, and this includes writes and no-ops. Read data is pipelined by one command. The word pushed for a command carries the value fetched by the command before it. Software therefore follows a read with a no-op, discards the first word it pops, and takes the register value from the second.

The processor side also has the following registers:
- a configuration register, holding the engine enable, the divider select and two stored edge options;
- sticky interrupt flags, cleared by writing 1, and a mask register;
- a queue status register;
- a misc control scratch register.

Top module: `adc_cmd_bridge`

## Requirements
- R1: After reset, config, interrupt flags, mask and misc control all read 0. The status register reads 0x0000_0500, meaning both queues are empty and the result level is 0.
- R2: A command word holds the opcode in bits 29:26, the register address in bits 25:16 and the write data in bits 15:0. Opcode 0 is a no-op, 1 is a read and 2 is a write. Every other opcode acts as a no-op and writes nothing. Bits 31:30 are ignored.
- R3: Each command the engine completes pushes exactly one word into the result queue, whatever its opcode.
- R4: The word pushed for a command holds, in bits 15:0, the value that the previous command read. If the previous command was not a read, those bits are zero. Bits 31:16 of a popped word are always zero.
- R5: While config bit 31 (enable) is clear, commands stay in the command queue and none of them is executed.
- R6: Config bits 9:8 hold n, which divides the clock by 2^(n+1), so n = 1 gives divide-by-4. Suppose a command is pushed into an empty queue while the engine is idle. The result level then becomes 1 right after the 32*2^(n+1)+2-th rising edge that follows the push edge.
- R7: The command queue holds 16 words. A push at offset 0x10 while the queue is full drops the word and sets sticky interrupt bit 0.
- R8: A pop at offset 0x14 while the result queue is empty returns 0 and sets sticky interrupt bit 1.
- R9: Writing 1 to a bit of the interrupt register at 0x04 clears that bit. The mask register at 0x08 stores bits 1:0.
- R10: The status register at 0x0C reports:
  - the result level in bits 4:0;
  - result-queue empty in bit 8;
  - result-queue full in bit 9;
  - command-queue empty in bit 10;
  - command-queue full in bit 11.
- R11: The backend implements register addresses 0 to 63. A read at address 64 or above returns 0. A write there changes no register, so it does not alias onto address modulo 64.
- R12: When the result queue is full, a finished command waits and pushes nothing. Once a word is popped, the waiting command pushes its word, and no result is lost.
- R13: The config register at 0x00 reads back only bits 31, 13, 12 and 9:8. Misc control at 0x18 reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the result queue at 0x14) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
Register reads are combinational, so the bench samples a register one time step after it drives the address. The one exception is the pop port, whose queue head is sampled before the edge that removes it.

A command's result is due 32*2^(n+1)+2 edges after its push edge: one edge for the engine to take the command, 32*2^(n+1) cycles of shifting, and one finishing edge that pushes the result. The bench counts edges to check this exact figure for two divider settings. Elsewhere it polls the result level with a bounded wait before it pops.

The overflow and underflow flags are due on the edge right after the offending access, and the bench reads them back straight after that edge. The "queued, not executed" and "stalled" conditions are checked after a fixed wait of 300 cycles. That wait is longer than two full command times.

// File: rtl/adc_bridge_pkg.sv
package adc_bridge_pkg;

    localparam int BUS_AW     = 5;
    localparam int REG_AW     = 10;
    localparam int REG_DW     = 16;
    localparam int OP_W       = 4;
    localparam int CMD_STORE_W = OP_W + REG_AW + REG_DW;

    localparam logic [BUS_AW-1:0] OFS_CONFIG  = 5'h00;
    localparam logic [BUS_AW-1:0] OFS_IRQ_FLG = 5'h04;
    localparam logic [BUS_AW-1:0] OFS_IRQ_MSK = 5'h08;
    localparam logic [BUS_AW-1:0] OFS_STATUS  = 5'h0C;
    localparam logic [BUS_AW-1:0] OFS_CMD_IN  = 5'h10;
    localparam logic [BUS_AW-1:0] OFS_RES_OUT = 5'h14;
    localparam logic [BUS_AW-1:0] OFS_MISC    = 5'h18;

    localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
    localparam logic [OP_W-1:0] OP_READ  = 4'd1;
    localparam logic [OP_W-1:0] OP_WRITE = 4'd2;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } eng_state_e;

endpackage

// File: rtl/bridge_fifo.sv
module bridge_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == LVL_W'(DEPTH));
    assign level   = count;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (!do_push && do_pop) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/backend_regs.sv
module backend_regs #(
    parameter int DEPTH = 64,
    parameter int AW    = 10,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DW-1:0] regs [DEPTH];
    logic          in_range;

    assign in_range = ({1'b0, addr} < LIMIT);
    assign rdata    = in_range ? regs[addr[IW-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && in_range) begin
            regs[addr[IW-1:0]] <= wdata;
        end
    end
endmodule

// File: rtl/cmd_engine.sv
module cmd_engine
    import adc_bridge_pkg::*;
#(
    parameter int TICKS = 32,
    parameter int DIV_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic [DIV_W-1:0]       div_sel,
    input  logic                   cmd_valid,
    input  logic [CMD_STORE_W-1:0] cmd_word,
    output logic                   cmd_pop,
    input  logic                   rsp_full,
    output logic                   rsp_push,
    output logic [REG_DW-1:0]      rsp_word,
    output logic                   reg_we,
    output logic [REG_AW-1:0]      reg_addr,
    output logic [REG_DW-1:0]      reg_wdata,
    input  logic [REG_DW-1:0]      reg_rdata
);
    localparam int PRE_W  = (2 ** DIV_W) + 1;
    localparam int TCNT_W = $clog2(TICKS);
    localparam logic [TCNT_W-1:0] LAST_TICK = TCNT_W'(TICKS-1);

    eng_state_e        state, nxt;
    cmd_t              cur;
    logic [REG_DW-1:0] pend_q;
    logic [PRE_W-1:0]  pre_cnt, pre_lim;
    logic [TCNT_W-1:0] tick_cnt;
    logic              tick;

    assign pre_lim = (PRE_W'(1) << ({1'b0, div_sel} + 1'b1)) - 1'b1;
    assign tick    = (pre_cnt == pre_lim);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (enable && cmd_valid)           nxt = ST_SHIFT;
            ST_SHIFT:  if (tick && tick_cnt == LAST_TICK) nxt = ST_FINISH;
            ST_FINISH: if (!rsp_full)                     nxt = ST_IDLE;
            default:                                      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_pop   = 1'b0;
        rsp_push  = 1'b0;
        unique case (state)
            ST_IDLE:   cmd_pop  = enable && cmd_valid;
            ST_SHIFT:  ;
            ST_FINISH: rsp_push = !rsp_full;
            default:   ;
        endcase
        reg_we    = rsp_push && (cur.op == OP_WRITE);
        reg_addr  = cur.addr;
        reg_wdata = cur.data;
        rsp_word  = pend_q;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= '0;
            pend_q   <= '0;
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else begin
            if (cmd_pop) cur <= cmd_t'(cmd_word);
            if (rsp_push) pend_q <= (cur.op == OP_READ) ? reg_rdata : '0;
            if (state != ST_SHIFT) begin
                pre_cnt  <= '0;
                tick_cnt <= '0;
            end else if (tick) begin
                pre_cnt  <= '0;
                tick_cnt <= tick_cnt + 1'b1;
            end else begin
                pre_cnt  <= pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_cmd_bridge.sv
module adc_cmd_bridge
    import adc_bridge_pkg::*;
#(
    parameter int FIFO_DEPTH    = 16,
    parameter int BACKEND_DEPTH = 64,
    parameter int TICKS_PER_CMD = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int LVL_W = $clog2(FIFO_DEPTH+1);

    logic        cfg_en, cfg_wedge, cfg_redge;
    logic [1:0]  cfg_div;
    logic [1:0]  int_sts, int_mask;
    logic [31:0] misc_q;

    logic                   cmd_push, cmd_pop, cmd_empty, cmd_full;
    logic [CMD_STORE_W-1:0] cmd_head;
    logic [LVL_W-1:0]       cmd_level;
    logic                   rd_pop, rsp_push, rd_empty, rd_full;
    logic [REG_DW-1:0]      rsp_word, rd_head;
    logic [LVL_W-1:0]       rd_level;
    logic                   reg_we;
    logic [REG_AW-1:0]      reg_addr;
    logic [REG_DW-1:0]      reg_wdata, reg_rdata;
    logic [31:0]            status_w;

    assign cmd_push = bus_wr && (bus_addr == OFS_CMD_IN);
    assign rd_pop   = bus_rd && (bus_addr == OFS_RES_OUT);

    bridge_fifo #(.W(CMD_STORE_W), .DEPTH(FIFO_DEPTH)) u_cmd_q (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .wdata(bus_wdata[CMD_STORE_W-1:0]),
        .pop(cmd_pop), .rdata(cmd_head), .empty(cmd_empty), .full(cmd_full),
        .level(cmd_level));

    bridge_fifo #(.W(REG_DW), .DEPTH(FIFO_DEPTH)) u_res_q (
        .clk(clk), .rst_n(rst_n), .push(rsp_push), .wdata(rsp_word),
        .pop(rd_pop), .rdata(rd_head), .empty(rd_empty), .full(rd_full),
        .level(rd_level));

    cmd_engine #(.TICKS(TICKS_PER_CMD), .DIV_W(2)) u_engine (
        .clk(clk), .rst_n(rst_n), .enable(cfg_en), .div_sel(cfg_div),
        .cmd_valid(!cmd_empty), .cmd_word(cmd_head), .cmd_pop(cmd_pop),
        .rsp_full(rd_full), .rsp_push(rsp_push), .rsp_word(rsp_word),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata));

    backend_regs #(.DEPTH(BACKEND_DEPTH), .AW(REG_AW), .DW(REG_DW)) u_backend (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en    <= 1'b0;
            cfg_wedge <= 1'b0;
            cfg_redge <= 1'b0;
            cfg_div   <= '0;
            int_sts   <= '0;
            int_mask  <= '0;
            misc_q    <= '0;
        end else begin
            if (bus_wr && bus_addr == OFS_CONFIG) begin
                cfg_en    <= bus_wdata[31];
                cfg_wedge <= bus_wdata[13];
                cfg_redge <= bus_wdata[12];
                cfg_div   <= bus_wdata[9:8];
            end
            if (bus_wr && bus_addr == OFS_IRQ_MSK) int_mask <= bus_wdata[1:0];
            if (bus_wr && bus_addr == OFS_MISC)    misc_q   <= bus_wdata;
            int_sts <= (int_sts & ~((bus_wr && bus_addr == OFS_IRQ_FLG) ? bus_wdata[1:0] : 2'b00))
                     | {rd_pop && rd_empty, cmd_push && cmd_full};
        end
    end

    always_comb begin
        status_w              = '0;
        status_w[LVL_W-1:0]   = rd_level;
        status_w[8]           = rd_empty;
        status_w[9]           = rd_full;
        status_w[10]          = cmd_empty;
        status_w[11]          = cmd_full;
    end

    always_comb begin
        case (bus_addr)
            OFS_CONFIG:  bus_rdata = {cfg_en, 17'b0, cfg_wedge, cfg_redge, 2'b0, cfg_div, 8'b0};
            OFS_IRQ_FLG: bus_rdata = {30'b0, int_sts};
            OFS_IRQ_MSK: bus_rdata = {30'b0, int_mask};
            OFS_STATUS:  bus_rdata = status_w;
            OFS_RES_OUT: bus_rdata = rd_empty ? 32'b0 : {16'b0, rd_head};
            OFS_MISC:    bus_rdata = misc_q;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_bridge_checks.sv
module adc_bridge_checks
    import adc_bridge_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [BUS_AW-1:0]          bus_addr,
    input logic                       cmd_full,
    input logic                       rd_empty,
    input logic                       rd_full,
    input logic [$clog2(DEPTH+1)-1:0] rd_level,
    input logic [$clog2(DEPTH+1)-1:0] cmd_level,
    input logic [1:0]                 int_sts,
    input logic                       cmd_pop,
    input logic                       cfg_en,
    input logic                       rsp_push
);
    localparam int LVL_W = $clog2(DEPTH+1);

    assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CMD_IN && cmd_full) |=> int_sts[0]);

    assert_cmd_capacity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_level <= LVL_W'(DEPTH));

    assert_underflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_RES_OUT && rd_empty) |=> int_sts[1]);

    assert_hold_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pop |-> cfg_en);

    assert_no_push_when_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_push |-> !rd_full);

    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_level <= LVL_W'(DEPTH));
endmodule

bind adc_cmd_bridge adc_bridge_checks #(.DEPTH(FIFO_DEPTH)) u_checks (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .cmd_full(cmd_full), .rd_empty(rd_empty), .rd_full(rd_full), .rd_level(rd_level),
    .cmd_level(cmd_level), .int_sts(int_sts), .cmd_pop(cmd_pop), .cfg_en(cfg_en),
    .rsp_push(rsp_push));

// File: tb/test_adc_cmd_bridge.sv
`timescale 1ns/1ps
module test_adc_cmd_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_cmd_bridge i_adc_cmd_bridge (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    // {command word, expected popped word}
    localparam logic [63:0] VEC [13] = '{
        {32'h0805_A5A5, 32'h0000_0000},  // write 5 = A5A5
        {32'h0405_0000, 32'h0000_0000},  // read 5 (previous was write)
        {32'h0000_0000, 32'h0000_A5A5},  // no-op returns read 5
        {32'h0807_1234, 32'h0000_0000},  // write 7 = 1234
        {32'h0407_0000, 32'h0000_0000},  // read 7
        {32'h0405_0000, 32'h0000_1234},  // read 5, returns read 7
        {32'h0C07_BEEF, 32'h0000_A5A5},  // opcode 3: no-op, returns read 5
        {32'h0407_0000, 32'h0000_0000},  // read 7 (prev not read)
        {32'h0864_FFFF, 32'h0000_1234},  // write 100 (out of range); 7 untouched by opcode 3
        {32'h0464_0000, 32'h0000_0000},  // read 100
        {32'h0424_7777, 32'h0000_0000},  // read 36, returns read 100 = 0
        {32'h0000_0000, 32'h0000_0000},  // 36 not aliased by 100
        {32'hC000_0000, 32'h0000_0000}   // bits 31:30 ignored, no-op
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_level(input int lvl);
        bus_addr = 5'h0C;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            #1;
            if (int'(bus_rdata[4:0]) >= lvl) break;
        end
    endtask

    task automatic measure(input int p, input string req);
        int n;
        bus_write(5'h10, 32'h0000_0000);
        bus_addr = 5'h0C;
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            n++;
            #1;
            if (bus_rdata[4:0] == 5'd1) break;
        end
        check(req, n, 32 * p + 2);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'h0C, v); check("R1 status", v, 32'h0000_0500);
        bus_read(5'h00, v); check("R1 config", v, 32'h0);
        bus_read(5'h04, v); check("R1 irq", v, 32'h0);
        bus_read(5'h08, v); check("R1 mask", v, 32'h0);
        bus_read(5'h18, v); check("R1 misc", v, 32'h0);

        // R8 underflow, R9 write-1-to-clear
        bus_read(5'h14, v); check("R8 empty pop", v, 32'h0);
        bus_read(5'h04, v); check("R8 flag", v, 32'h2);
        bus_write(5'h04, 32'h2);
        bus_read(5'h04, v); check("R9 w1c", v, 32'h0);
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_read(5'h08, v); check("R9 mask", v, 32'h3);

        // R13 readback
        bus_write(5'h00, 32'hFFFF_FFFF);
        bus_read(5'h00, v); check("R13 config", v, 32'h8000_3300);
        bus_write(5'h18, 32'hDEAD_ABCD);
        bus_read(5'h18, v); check("R13 misc", v, 32'hDEAD_ABCD);

        // R6 pacing, R3 one word per command
        bus_write(5'h00, 32'h8000_0100);
        measure(4, "R6 div4");
        bus_read(5'h14, v); check("R3 nop word", v, 32'h0);
        bus_write(5'h00, 32'h8000_0000);
        measure(2, "R6 div2");
        bus_read(5'h14, v); check("R3 nop word", v, 32'h0);

        // R2 R4 R11 vector table
        foreach (VEC[k]) begin
            bus_write(5'h10, VEC[k][63:32]);
            wait_level(1);
            repeat (4) @(negedge clk);
            bus_read(5'h0C, v); check("R3 level one", {27'b0, v[4:0]}, 32'd1);
            bus_read(5'h14, v); check("R4 R2 R11 vector", v, VEC[k][31:0]);
        end

        // R5 hold while disabled, R7 overflow
        bus_write(5'h00, 32'h0000_0000);
        bus_write(5'h10, 32'h0809_5A5A);
        bus_write(5'h10, 32'h0409_0000);
        for (int i = 0; i < 14; i++) bus_write(5'h10, 32'h0);
        bus_write(5'h10, 32'h0809_0000);
        bus_read(5'h04, v); check("R7 overflow flag", v, 32'h1);
        repeat (300) @(negedge clk);
        bus_read(5'h0C, v); check("R5 R10 queued", v, 32'h0000_0900);
        bus_write(5'h04, 32'h1);
        bus_read(5'h04, v); check("R9 w1c", v, 32'h0);

        // R12 stall on full result queue
        bus_write(5'h00, 32'h8000_0000);
        wait_level(16);
        bus_write(5'h10, 32'h0409_0000);
        bus_write(5'h10, 32'h0000_0000);
        repeat (300) @(negedge clk);
        bus_read(5'h0C, v); check("R12 R10 stalled", v, 32'h0000_0210);
        for (int i = 0; i < 16; i++) begin
            bus_read(5'h14, v);
            check("R12 drained word", v, (i == 2) ? 32'h0000_5A5A : 32'h0);
        end
        wait_level(2);
        bus_read(5'h14, v); check("R12 late word", v, 32'h0);
        bus_read(5'h14, v); check("R7 dropped write", v, 32'h0000_5A5A);
        bus_read(5'h0C, v); check("R10 idle status", v, 32'h0000_0500);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule